// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions on a PHY's two-wire serial management bus. Software places a complete 32-bit frame word (start, opcode, PHY address, register number, turnaround and data) into the data register in one write. The block then produces the management clock from the system clock, sends thirty-two idle ones followed by the frame word MSB first, and sets an event flag when the last bit has gone out.

On a read frame the block stops driving the data line for the second turnaround bit and the data phase. It shifts the sixteen bits returned by the PHY into the low half of the data register, so software can poll the event flag and then read the result from the same register. The clock rate comes from a speed register: each clock half period lasts that many system cycles. A speed of zero keeps the clock stopped and blocks any new frame. The data line is presented as separate output, output-enable and input pins for a pad cell.

Top module: `mdio_master`

## Requirements
- R1: After a frame starts, the data output carries 32 ones and then the 32 bits of the command word, MSB first. The line changes only together with a falling edge of the management clock, so each bit is stable at the rising edge. A read command is 0x60020000 with the PHY address in bits 27:23 and the register number in bits 22:18. A write command is 0x50020000 with the same address and register fields and the write data in bits 15:0.
- R2: The management clock is low while idle. During a frame each low half and each high half lasts exactly `speed` system cycles, using the speed value held when the frame started. A frame is 64 clock periods, and the event flag reads as set 128×speed cycles after the clock edge that accepted the command.
- R3: The output enable is active for the whole of a write frame. On a read frame (command bits 29:28 equal to 2'b10) it is dropped from command bit 16, which is frame bit 47, until the frame ends. It is inactive while idle.
- R4: On a read frame, the input line is sampled at the system clock edge where the management clock rises, for command bits 15 down to 0, MSB first. The samples are shifted into data register bits 15:0. Bits 31:16 keep the command.
- R5: After a write frame the data register still holds the command word that was written.
- R6: The event flag is bit 23 of the register at offset 2. It is set when a frame ends. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R7: While the speed value is 0, a write to the data register is ignored. No frame starts, the register keeps its value, the clock stays low and no event is raised.
- R8: A write to the data register while a frame is in progress is ignored. The running frame keeps its command and the register is not overwritten.
- R9: After reset the clock is low, the output enable is inactive, and the data, speed and event registers read 0.
- R10: Register offsets: 0 is the data register, 1 is the speed value in bits SPD_W-1:0 (higher bits read 0), 2 is the event register, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 2 | Register offset for read and write |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioIn | input | 1 | Data line as seen at the pad |
| mdioOut | output | 1 | Value driven on the data line |
| mdioOe | output | 1 | Drive enable for the data line |

## Verification
The bound checker watches several properties on every cycle. The data line and its enable may move only at a falling edge of the management clock. Each clock half period must match the speed value captured at frame start. The clock must be low whenever no frame is active. Once released inside a frame, the line stays released until the frame ends. The event flag may rise only at a frame-end strobe. The exact bit stream, the turnaround release point, the captured read data, event clearing, and the rejection of writes at speed zero or during a frame depend on command values and bus traffic. Only the bench scenarios, which replay and compare whole frames, can show those.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Protocol geometry: idle preamble, then the 32-bit command word.
  localparam int PRE_BITS   = 32;
  localparam int CMD_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  // Frame bit index where a read stops driving (command bit 16) and starts capturing.
  localparam int REL_BIT    = PRE_BITS + (CMD_BITS - 1 - DATA_W);
  localparam int CAP_BIT    = PRE_BITS + (CMD_BITS - DATA_W);
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int EVT_POS    = 23;

  localparam logic [1:0] OFS_DATA  = 2'd0;
  localparam logic [1:0] OFS_SPEED = 2'd1;
  localparam logic [1:0] OFS_EVENT = 2'd2;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;      // accept command, begin frame
    logic shift;     // advance command shifter (at clock fall)
    logic sample;    // clock rises on this edge
    logic done;      // last half period ends
    logic active;    // frame in progress
    logic preamble;  // sending idle ones
    logic relPhase;  // second turnaround bit onward
    logic capPhase;  // data phase
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [SPD_W-1:0]  speedVal,
  output mdioStrobe_t       stb,
  output logic              mdc
);
  logic             busy;
  logic             mdcHigh;
  logic [SPD_W-1:0] divCnt;
  logic [SPD_W-1:0] spdQ;
  logic [IDX_W-1:0] bitIdx;
  logic             halfEnd;
  logic             lastBit;
  logic             advance;

  always_comb begin
    halfEnd      = busy && (divCnt == spdQ - SPD_W'(1));
    lastBit      = (bitIdx == IDX_W'(FRAME_BITS - 1));
    advance      = halfEnd && mdcHigh;
    stb.load     = startReq && !busy && (speedVal != '0);
    stb.shift    = advance && !lastBit && (bitIdx >= IDX_W'(PRE_BITS));
    stb.sample   = halfEnd && !mdcHigh;
    stb.done     = advance && lastBit;
    stb.active   = busy;
    stb.preamble = busy && (bitIdx < IDX_W'(PRE_BITS));
    stb.relPhase = busy && (bitIdx >= IDX_W'(REL_BIT));
    stb.capPhase = busy && (bitIdx >= IDX_W'(CAP_BIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdcHigh <= 1'b0;
      divCnt  <= '0;
      spdQ    <= '0;
      bitIdx  <= '0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      mdcHigh <= 1'b0;
      divCnt  <= '0;
      spdQ    <= speedVal;
      bitIdx  <= '0;
    end else if (busy) begin
      if (halfEnd) begin
        divCnt  <= '0;
        mdcHigh <= !mdcHigh;
        if (advance) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + IDX_W'(1);
        end
      end else begin
        divCnt <= divCnt + SPD_W'(1);
      end
    end
  end

  assign mdc = mdcHigh;
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       stb,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [31:0]       busWrData,
  input  logic              mdioIn,
  output logic [31:0]       busRdData,
  output logic [SPD_W-1:0]  speedVal,
  output logic              startReq,
  output logic              eventFlag,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic [CMD_BITS-1:0] dataReg;
  logic [CMD_BITS-1:0] shReg;
  logic [SPD_W-1:0]    speedReg;
  logic                evtReg;
  logic                isRead;
  logic                wrData;
  logic                wrSpeed;
  logic                wrEvent;

  assign wrData  = busWrEn && (busAddr == OFS_DATA);
  assign wrSpeed = busWrEn && (busAddr == OFS_SPEED);
  assign wrEvent = busWrEn && (busAddr == OFS_EVENT);
  assign startReq = wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      shReg   <= '0;
      isRead  <= 1'b0;
    end else if (stb.load) begin
      dataReg <= busWrData;
      shReg   <= busWrData;
      isRead  <= (busWrData[OP_HI:OP_LO] == OP_READ);
    end else begin
      if (stb.shift) shReg <= {shReg[CMD_BITS-2:0], 1'b0};
      if (stb.sample && stb.capPhase && isRead)
        dataReg[DATA_W-1:0] <= {dataReg[DATA_W-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        speedReg <= '0;
    else if (wrSpeed) speedReg <= busWrData[SPD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              evtReg <= 1'b0;
    else if (stb.done)                      evtReg <= 1'b1;
    else if (wrEvent && busWrData[EVT_POS]) evtReg <= 1'b0;
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_DATA:  busRdData = dataReg;
      OFS_SPEED: busRdData[SPD_W-1:0] = speedReg;
      OFS_EVENT: busRdData[EVT_POS] = evtReg;
      default:   busRdData = '0;
    endcase
  end

  assign speedVal  = speedReg;
  assign eventFlag = evtReg;
  assign mdioOe    = stb.active && !(isRead && stb.relPhase);
  assign mdioOut   = (!stb.active || stb.preamble) ? 1'b1 : shReg[CMD_BITS-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe
);
  mdioStrobe_t      stb;
  logic [SPD_W-1:0] speedVal;
  logic             startReq;
  logic             eventFlag;

  mdio_ctrl #(.SPD_W(SPD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .speedVal (speedVal),
    .stb      (stb),
    .mdc      (mdc)
  );

  mdio_datapath #(.SPD_W(SPD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .mdioIn    (mdioIn),
    .busRdData (busRdData),
    .speedVal  (speedVal),
    .startReq  (startReq),
    .eventFlag (eventFlag),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioOut,
  input logic             mdioOe,
  input mdioStrobe_t      stb,
  input logic [SPD_W-1:0] speedVal,
  input logic             eventFlag
);
  logic             mdcQ;
  logic [SPD_W:0]   runLen;
  logic [SPD_W-1:0] spdCk;

  // Length of the current clock level, counted in system cycles.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcQ   <= 1'b0;
      runLen <= '0;
      spdCk  <= '0;
    end else begin
      mdcQ <= mdc;
      if (stb.load) begin
        runLen <= '0;
        spdCk  <= speedVal;
      end else if (mdc != mdcQ) begin
        runLen <= (SPD_W+1)'(1);
      end else begin
        runLen <= runLen + (SPD_W+1)'(1);
      end
    end
  end

  // R1: line and enable move only at a clock fall while a frame runs
  assert_mdio_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && $past(stb.active) && !$fell(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));

  // R2: each half period equals the speed captured at frame start
  assert_mdc_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && !stb.load && (mdc != mdcQ)) |-> (runLen == {1'b0, spdCk}));

  // R2: clock parked low outside frames
  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |-> !mdc);

  // R3: once released in a frame, the line stays released until it ends
  assert_release_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && !mdioOe) |=> (!mdioOe || !stb.active));

  // R6: event only rises after a frame-end strobe
  assert_event_from_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eventFlag) |-> $past(stb.done));
endmodule

bind mdio_master mdio_master_chk #(.SPD_W(SPD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .mdc       (mdc),
  .mdioOut   (mdioOut),
  .mdioOe    (mdioOe),
  .stb       (stb),
  .speedVal  (speedVal),
  .eventFlag (eventFlag)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdat;
    logic [5:0]  spd;
    logic [15:0] phyData;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'd1,  5'd2,  16'h0000, 6'd2, 16'hA5C3},
    '{1'b1, 5'd3,  5'd4,  16'h1234, 6'd3, 16'h0000},
    '{1'b0, 5'd31, 5'd31, 16'h0000, 6'd1, 16'h0001},
    '{1'b0, 5'd0,  5'd0,  16'h0000, 6'd4, 16'h8000},
    '{1'b1, 5'd21, 5'd10, 16'hFFFF, 6'd2, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc;
  logic        mdioIn = 1'b1;
  logic        mdioOut;
  logic        mdioOe;

  int checks = 0;
  int errors = 0;
  logic obsOut [64];
  logic obsOe  [64];
  int rises, hiCnt, nWait;

  mdio_master u_mdio_master (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  always #2ns clk = ~clk;

  function automatic logic [31:0] mkCmd(input logic wr, input logic [4:0] phy,
                                        input logic [4:0] regn, input logic [15:0] wdat);
    logic [31:0] base;
    base = wr ? 32'h50020000 : 32'h60020000;
    return base | (32'(phy) << 23) | (32'(regn) << 18) | (wr ? 32'(wdat) : 32'h0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1ns;
    d = busRdData;
  endtask

  // Start a frame and follow it at negedges, acting as the PHY on reads.
  task automatic runFrame(input logic [31:0] cmd, input logic [5:0] spd, input logic [15:0] phyData,
                          input int midAt, input logic [31:0] midCmd);
    logic prev;
    logic fin;
    wrReg(2'd1, 32'(spd));
    mdioIn = 1'b1;
    wrReg(2'd0, cmd);
    rises = 0; hiCnt = 0; nWait = 1; prev = mdc;
    busAddr = 2'd2;
    #1ns;
    fin = busRdData[23];
    while (!fin && nWait < 20000) begin
      @(negedge clk);
      nWait++;
      if (nWait == midAt) begin
        busWrEn = 1'b1; busAddr = 2'd0; busWrData = midCmd;
      end else begin
        busWrEn = 1'b0; busAddr = 2'd2;
      end
      if (mdc) hiCnt++;
      if (mdc && !prev) begin
        if (rises < 64) begin
          obsOut[rises] = mdioOut;
          obsOe[rises]  = mdioOe;
        end
        rises++;
      end
      prev = mdc;
      mdioIn = (rises >= 48 && rises < 64) ? phyData[63-rises] : 1'b1;
      #1ns;
      fin = (busAddr == 2'd2) && busRdData[23];
    end
  endtask

  task automatic checkFrame(input logic [31:0] cmd, input logic wr, input logic [5:0] spd, input string tag);
    logic [63:0] expBits;
    int bitErr;
    int oeErr;
    expBits = {32'hFFFFFFFF, cmd};
    bitErr = 0; oeErr = 0;
    for (int k = 0; k < 64; k++) begin
      logic expOe;
      expOe = wr ? 1'b1 : (k < 47);
      if (obsOe[k] !== expOe) oeErr++;
      if (expOe && (obsOut[k] !== expBits[63-k])) bitErr++;
    end
    check(nWait == 128*spd + 1, {tag, " R2 frame length"}, 32'(nWait), 32'(128*spd + 1));
    check(hiCnt == 64*spd, {tag, " R2 clock high cycles"}, 32'(hiCnt), 32'(64*spd));
    check(rises == 64, {tag, " R2 clock pulses"}, 32'(rises), 32'd64);
    check(bitErr == 0, {tag, " R1 serial bits"}, 32'(bitErr), 32'd0);
    check(oeErr == 0, {tag, " R3 enable pattern"}, 32'(oeErr), 32'd0);
    check(!mdc && !mdioOe, {tag, " R3 idle released"}, {30'd0, mdc, mdioOe}, 32'd0);
  endtask

  initial begin
    #700us;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] cmd;
    logic [31:0] cmdB;
    int hiSeen;
    int oeSeen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(!mdc && !mdioOe, "R9 pins after reset", {30'd0, mdc, mdioOe}, 32'd0);
    rdReg(2'd0, rd); check(rd == 0, "R9 data reset", rd, 32'd0);
    rdReg(2'd1, rd); check(rd == 0, "R9 speed reset", rd, 32'd0);
    rdReg(2'd2, rd); check(rd == 0, "R9 event reset", rd, 32'd0);

    // R10 register map
    wrReg(2'd1, 32'hFFFFFFC5);
    rdReg(2'd1, rd); check(rd == 32'h5, "R10 speed field", rd, 32'h5);
    rdReg(2'd3, rd); check(rd == 0, "R10 unused offset", rd, 32'd0);
    wrReg(2'd1, 32'h0);

    // R7 speed zero blocks frames
    wrReg(2'd0, mkCmd(1'b0, 5'd2, 5'd1, 16'h0));
    hiSeen = 0; oeSeen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc) hiSeen++;
      if (mdioOe) oeSeen++;
    end
    check(hiSeen == 0 && oeSeen == 0, "R7 no clock or drive", 32'(hiSeen + oeSeen), 32'd0);
    rdReg(2'd0, rd); check(rd == 0, "R7 data unchanged", rd, 32'd0);
    rdReg(2'd2, rd); check(rd == 0, "R7 no event", rd, 32'd0);

    // Vector table: R1..R6
    for (int v = 0; v < NVEC; v++) begin
      cmd = mkCmd(VECS[v].wr, VECS[v].phy, VECS[v].regn, VECS[v].wdat);
      runFrame(cmd, VECS[v].spd, VECS[v].phyData, -1, 32'h0);
      checkFrame(cmd, VECS[v].wr, VECS[v].spd, $sformatf("vec%0d", v));
      rdReg(2'd0, rd);
      if (VECS[v].wr)
        check(rd == cmd, "R5 data after write", rd, cmd);
      else
        check(rd == {cmd[31:16], VECS[v].phyData}, "R4 read capture", rd, {cmd[31:16], VECS[v].phyData});
      rdReg(2'd2, rd); check(rd == 32'h00800000, "R6 event set", rd, 32'h00800000);
      wrReg(2'd2, 32'hFF7FFFFF);
      rdReg(2'd2, rd); check(rd == 32'h00800000, "R6 zero write keeps", rd, 32'h00800000);
      wrReg(2'd2, 32'h00800000);
      rdReg(2'd2, rd); check(rd == 0, "R6 one write clears", rd, 32'd0);
    end

    // R8 data write during a frame is ignored
    cmd  = mkCmd(1'b0, 5'd9, 5'd17, 16'h0);
    cmdB = mkCmd(1'b1, 5'd30, 5'd5, 16'hBEEF);
    runFrame(cmd, 6'd2, 16'h3C5A, 100, cmdB);
    checkFrame(cmd, 1'b0, 6'd2, "R8 frame");
    rdReg(2'd0, rd);
    check(rd == {cmd[31:16], 16'h3C5A}, "R8 data kept", rd, {cmd[31:16], 16'h3C5A});
    wrReg(2'd2, 32'h00800000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule